// File: doc/BRIEF.md
# Prescaled Tick Generator for Five Timer Channels

This block turns one reference clock into five count-enable strobes, one per down-counting timer channel. It holds two configuration words. The prescale word carries two 8-bit prescale values. The divide word carries one 4-bit power-of-two select per channel. Channels 0 and 1 share the low prescaler, and channels 2, 3 and 4 share the high one. Each channel then divides that shared stage rate by its own power of two.

A channel's strobe lasts one reference cycle. It fires once every (prescale + 1) × 2^select cycles. Both configuration words are loaded together on a single write strobe. That write also restarts every prescale and divide counter. The first strobe at the new rate therefore arrives one full period after the write.

Top module: `pwm_tick_gen`

## Requirements
- R1: After reset the prescale word is 0x0101 and the divide word is 0. Every channel then strobes every second cycle, and the first strobe comes in the second cycle after reset is released.
- R2: A channel strobes for exactly one cycle every (p + 1) × 2^s reference cycles. Here p is its prescale value and s is its 4-bit select. This holds up to p = 255 and s = 15.
- R3: Channels 0 and 1 take their prescale value from bits 7:0 of the prescale word. Channels 2, 3 and 4 take theirs from bits 15:8.
- R4: Channel x takes its divide select from bits 4x+3:4x of the divide word.
- R5: With prescale 0 and select 0, a channel's strobe is high in every cycle.
- R6: Both words are captured only in a cycle where the write strobe is high. Values on the word inputs at any other time have no effect.
- R7: Count cycle 0 as the cycle that follows the clock edge capturing the write strobe. Every channel then strobes first in cycle P − 1 and after that every P cycles, where P is the channel's new period.
- R8: While reset is asserted, no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Loads both configuration words and restarts all counters |
| pre_word | input | 16 | Two prescale values: low byte for channels 0–1, high byte for channels 2–4 |
| div_word | input | 20 | Five 4-bit divide selects, channel x at bits 4x+3:4x |
| tick | output | 5 | Single-cycle count enable, one bit per channel |

## Verification
Several assertions reason about the next cycle's strobe from the configuration seen in the current cycle. These assertions assume the word inputs are sampled only with the write strobe, and that the strobe is a clean synchronous pulse. The stimulus follows that rule. Each write is raised on a falling edge and dropped just after the capturing rising edge. The word inputs are then driven to the bitwise inverse of the values just written, so a design that kept listening to them would diverge from the model. Reset is held across several edges before its release, so no assertion evaluates counters that have not yet been initialised.

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int          N_CH    = 5,
  parameter int          PRE_W   = 8,
  parameter int          SEL_W   = 4,
  parameter int          N_LOW   = 2,
  parameter int unsigned PRE_RST = 32'h0101
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [2*PRE_W-1:0]     pre_word,
  input  logic [N_CH*SEL_W-1:0]  div_word,
  output logic [N_CH-1:0]        tick
);
  localparam int PW2 = 2 * PRE_W;
  localparam int DW  = N_CH * SEL_W;
  localparam int DCW = (1 << SEL_W) - 1;
  localparam logic [PW2-1:0] PRE_RST_V = PW2'(PRE_RST);

  logic [PW2-1:0] pre_q;
  logic [DW-1:0]  div_q;
  logic [1:0]     stage_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= PRE_RST_V;
      div_q <= '0;
    end else if (cfg_wr) begin
      pre_q <= pre_word;
      div_q <= div_word;
    end
  end

  a_r6_words_held: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(pre_q) && $stable(div_q)));

  for (genvar p = 0; p < 2; p++) begin : g_pre
    logic [PRE_W-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pcnt <= PRE_RST_V[p*PRE_W +: PRE_W];
      else if (cfg_wr)           pcnt <= pre_word[p*PRE_W +: PRE_W];
      else if (pcnt == '0)       pcnt <= pre_q[p*PRE_W +: PRE_W];
      else                       pcnt <= pcnt - PRE_W'(1);
    end

    assign stage_en[p] = (pcnt == '0);
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int PS = (c < N_LOW) ? 0 : 1;
    logic [DCW-1:0]   dcnt;
    logic [DCW-1:0]   mask;
    logic [SEL_W-1:0] sel;
    logic [PRE_W-1:0] pre;

    assign sel  = div_q[c*SEL_W +: SEL_W];
    assign pre  = pre_q[PS*PRE_W +: PRE_W];
    assign mask = DCW'((32'd1 << sel) - 32'd1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             dcnt <= '0;
      else if (cfg_wr)        dcnt <= '0;
      else if (stage_en[PS])  dcnt <= dcnt + DCW'(1);
    end

    assign tick[c] = stage_en[PS] & ((dcnt & mask) == mask);

    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[c] && !cfg_wr && (pre != '0 || sel != '0)) |=> !tick[c]);

    a_r5_zero_always: assert property (@(posedge clk) disable iff (!rst_n)
      (pre == '0 && sel == '0) |-> tick[c]);

    a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && (pre_word[PS*PRE_W +: PRE_W] != '0 || div_word[c*SEL_W +: SEL_W] != '0))
      |=> !tick[c]);
  end

  a_r3_low_pair_match: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q[SEL_W-1:0] == div_q[2*SEL_W-1:SEL_W]) |-> (tick[0] == tick[1]));

endmodule

// File: tb/pwm_tick_gen_bench.sv
`timescale 1ns/1ps
module pwm_tick_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] pre_word = '0;
  logic [19:0] div_word = '0;
  logic [4:0]  tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int          m_p0, m_p1;
  int unsigned m_dv;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  pwm_tick_gen u_pwm_tick_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .pre_word(pre_word), .div_word(div_word), .tick(tick)
  );

  function automatic logic [4:0] model(int c);
    logic [4:0] r;
    for (int ch = 0; ch < 5; ch++) begin
      longint pre = (ch < 2) ? m_p0 : m_p1;
      longint sel = (m_dv >> (4 * ch)) & 15;
      longint per = (pre + 1) * (longint'(1) << sel);
      r[ch] = ((longint'(c) + 1) % per) == 0;
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (tick !== e) begin
        errors++;
        $display("FAIL %s tick got %b expected %b at %0t", t, tick, e, $time);
      end
    end
  end

  task automatic run(int c0, int n, string tag);
    for (int c = c0; c < c0 + n; c++) begin
      exp_q.push_back(model(c));
      tag_q.push_back(tag);
      @(posedge clk); #1;
    end
  endtask

  task automatic apply(int p0, int p1, int unsigned dv);
    @(negedge clk);
    pre_word = {p1[7:0], p0[7:0]};
    div_word = dv[19:0];
    cfg_wr   = 1'b1;
    @(posedge clk); #1;
    cfg_wr   = 1'b0;
    pre_word = ~{p1[7:0], p0[7:0]};
    div_word = ~dv[19:0];
    m_p0 = p0; m_p1 = p1; m_dv = dv;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (tick !== 5'b0) begin
        errors++;
        $display("FAIL R8 tick during reset got %b expected %b", tick, 5'b0);
      end
    end
    rst_n = 1'b1;
    m_p0 = 1; m_p1 = 1; m_dv = 0;
    @(posedge clk); #1;
    run(1, 20, "R1");

    apply(0, 0, 0);
    run(0, 10, "R5");

    apply(2, 4, 32'h43210);
    run(0, 400, "R4");

    apply(3, 0, 0);
    run(0, 40, "R3");

    apply(255, 0, 32'hF0002);
    run(0, 33000, "R2");

    apply(6, 6, 0);
    run(0, 5, "R7");
    apply(6, 6, 0);
    run(0, 20, "R7");

    apply(1, 2, 32'h11111);
    run(0, 60, "R6");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule